// File: doc/BRIEF.md
# I2C Addressed Byte-Memory Slave

This block lets an I2C master read and write a small on-chip byte RAM. It filters the oversampled SCL and SDA lines, finds START and STOP conditions, and checks the 7-bit device address and the direction bit. On a write it loads two address bytes into an internal pointer. Each data byte that follows is stored at the pointer, and the pointer then steps forward. On a read it sends the byte at the pointer and moves on to the next byte each time the master acknowledges.

The pointer keeps its value from one transaction to the next. A read that starts with no address phase therefore carries on from where the last access stopped. When the pointer passes its top address it wraps to zero. The RAM is outside the block. It is a plain synchronous port: the address is held at the pointer, write data is given with a one-cycle write strobe, and read data comes back one clock after the address. SDA is driven as open drain: while `sda_oe` is high the line is pulled low. While the write-inhibit input is high, the slave does not take part on the bus at all.

Top module: `i2c_ram_slave`

## Requirements
- R1: Bus bytes are sent most significant bit first. The first byte after a START holds the 7-bit device address in bits 7..1 and the direction bit in bit 0 (0 = write, 1 = read). When the address equals `DEV_ADDR`, the slave acknowledges by pulling SDA low during the ninth clock.
- R2: When the address does not match, the slave gives no acknowledge. It writes nothing and drives SDA for no further bytes until the next START.
- R3: The slave acknowledges the device byte and each of the two address bytes. `sda_oe` only becomes active in the cycle after the slave sees a falling edge of SCL.
- R4: On a write, the first byte after the device byte is the high address byte and the second is the low address byte. Together they load the pointer. Only the low `PTR_W` bits (15 by default) are kept, so bit 7 of the high byte is ignored.
- R5: On a write, each data byte is acknowledged and stored at the pointer. The pointer then increases by one.
- R6: On a read, the slave sends the byte at the pointer, MSB first. The pointer increases by one only when the master acknowledges that byte. A master NACK ends the read and leaves the pointer where it was.
- R7: When a write or a read goes past address 2^PTR_W-1, the pointer wraps to 0.
- R8: A read transaction with no address phase returns data starting at the pointer value left by earlier transactions.
- R9: While `wr_inhibit` is high, the slave gives no acknowledge, writes nothing and leaves the pointer unchanged.
- R10: A repeated START aborts the current byte and starts address matching again. A STOP returns the slave to idle, so a byte clocked after a STOP with no START in between gets no acknowledge.
- R11: After reset the pointer is 0 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low reset |
| scl_in | input | 1 | SCL line level, not synchronized |
| sda_in | input | 1 | SDA line level, not synchronized |
| sda_oe | output | 1 | High pulls SDA low |
| wr_inhibit | input | 1 | High makes the slave ignore the bus |
| ram_addr | output | PTR_W | RAM address, equal to the pointer |
| ram_we | output | 1 | One-cycle RAM write strobe |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, valid one clock after the address |

## Verification
The bench checks the pointer after a read that ends in a NACK. A design that also stepped on the NACK would make the following current-address read return the wrong byte. It writes and reads across the top address: a pointer that failed to wrap would put the second byte at a location that does not exist, and reading it back would return the wrong value. It sets bit 7 of the high address byte, which a design that kept that bit would turn into a different pointer. It also checks that SDA stays silent and no write happens in three cases: after a wrong address, while inhibited, and for a byte clocked after a STOP. Finally, it cuts a byte short with a repeated START. A design that did not restart on it would misframe the read that follows.

// File: rtl/i2cmem_pkg.sv
package i2cmem_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } bus_state_t;

  typedef enum logic [1:0] {
    K_DEV,
    K_AHI,
    K_ALO,
    K_DATA
  } byte_kind_t;

  function automatic logic [15:0] ptr_step(input logic [15:0] p, input logic [15:0] mask);
    return (p + 16'd1) & mask;
  endfunction

  function automatic logic [15:0] ptr_join(input logic [7:0] hi, input logic [7:0] lo,
                                           input logic [15:0] mask);
    return {hi, lo} & mask;
  endfunction

  function automatic logic dev_match(input logic [7:0] b, input logic [6:0] dev);
    return b[7:1] == dev;
  endfunction

  function automatic byte_kind_t kind_after(input byte_kind_t k);
    case (k)
      K_DEV:   return K_AHI;
      K_AHI:   return K_ALO;
      default: return K_DATA;
    endcase
  endfunction

endpackage

// File: rtl/i2cmem_sync.sv
module i2cmem_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  // index 0 = SCL, index 1 = SDA
  logic [1:0] raw;
  logic [1:0] now;
  logic [1:0] last;

  assign raw = {sda_in, scl_in};

  for (genvar i = 0; i < 2; i++) begin : g_line
    logic [STAGES-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '1;
      else        q <= {q[STAGES-2:0], raw[i]};
    end
    assign now[i] = q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last <= 2'b11;
    else        last <= now;
  end

  assign sda_s    = now[1];
  assign scl_rise = now[0] & ~last[0];
  assign scl_fall = ~now[0] & last[0];
  assign start_ev = now[0] & last[0] & last[1] & ~now[1];
  assign stop_ev  = now[0] & last[0] & ~last[1] & now[1];
endmodule

// File: rtl/i2cmem_ptr.sv
module i2cmem_ptr
  import i2cmem_pkg::*;
#(
  parameter int PTR_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [7:0]       hi,
  input  logic [7:0]       lo,
  input  logic             inc,
  output logic [PTR_W-1:0] ptr
);
  localparam logic [15:0] PTR_MASK = 16'((32'd1 << PTR_W) - 32'd1);

  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr_q <= '0;
    else if (load) ptr_q <= PTR_W'(ptr_join(hi, lo, PTR_MASK));
    else if (inc)  ptr_q <= PTR_W'(ptr_step(16'(ptr_q), PTR_MASK));
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/i2cmem_ctrl.sv
module i2cmem_ctrl
  import i2cmem_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h52
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic       sda_s,
  input  logic       wr_inhibit,
  input  logic [7:0] ram_rdata,
  output logic       sda_oe,
  output logic       ram_we,
  output logic [7:0] ram_wdata,
  output logic       ptr_load,
  output logic [7:0] ptr_hi,
  output logic [7:0] ptr_lo,
  output logic       ptr_inc
);
  bus_state_t state;
  byte_kind_t kind;
  logic [3:0] cnt;
  logic [7:0] shreg;
  logic [7:0] hi_q;
  logic [7:0] txreg;
  logic       rw_q;
  logic       oe_q;
  logic       mack_q;

  logic byte_done;
  logic mack_take;

  assign byte_done = (state == ST_RX) && (cnt == 4'd8) && scl_fall && !wr_inhibit;
  assign ram_we    = byte_done && (kind == K_DATA);
  assign ptr_load  = byte_done && (kind == K_ALO);
  assign mack_take = (state == ST_MACK) && scl_rise && !sda_s && !wr_inhibit;
  assign ptr_inc   = ram_we | mack_take;
  assign ram_wdata = shreg;
  assign ptr_hi    = hi_q;
  assign ptr_lo    = shreg;
  assign sda_oe    = oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      kind   <= K_DEV;
      cnt    <= '0;
      shreg  <= '0;
      hi_q   <= '0;
      txreg  <= '0;
      rw_q   <= 1'b0;
      oe_q   <= 1'b0;
      mack_q <= 1'b0;
    end else if (wr_inhibit || stop_ev) begin
      state <= ST_IDLE;
      oe_q  <= 1'b0;
    end else if (start_ev) begin
      state  <= ST_RX;
      kind   <= K_DEV;
      cnt    <= '0;
      oe_q   <= 1'b0;
      mack_q <= 1'b0;
    end else begin
      case (state)
        ST_RX: begin
          if (scl_rise && cnt != 4'd8) begin
            shreg <= {shreg[6:0], sda_s};
            cnt   <= cnt + 4'd1;
          end else if (byte_done) begin
            if (kind == K_DEV && !dev_match(shreg, DEV_ADDR)) begin
              state <= ST_IDLE;
            end else begin
              oe_q  <= 1'b1;
              state <= ST_ACK;
              if (kind == K_DEV) rw_q <= shreg[0];
              if (kind == K_AHI) hi_q <= shreg;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (kind == K_DEV && rw_q) begin
              state <= ST_TX;
              txreg <= ram_rdata;
              oe_q  <= ~ram_rdata[7];
            end else begin
              state <= ST_RX;
              kind  <= kind_after(kind);
              oe_q  <= 1'b0;
            end
            cnt <= '0;
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            cnt <= cnt + 4'd1;
          end else if (scl_fall) begin
            if (cnt == 4'd8) begin
              oe_q   <= 1'b0;
              state  <= ST_MACK;
              mack_q <= 1'b0;
            end else begin
              txreg <= {txreg[6:0], 1'b0};
              oe_q  <= ~txreg[6];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            if (!sda_s) mack_q <= 1'b1;
            else        state  <= ST_IDLE;
          end else if (scl_fall && mack_q) begin
            state  <= ST_TX;
            txreg  <= ram_rdata;
            oe_q   <= ~ram_rdata[7];
            cnt    <= '0;
            mack_q <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_ram_slave.sv
module i2c_ram_slave
  import i2cmem_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h52,
  parameter int         PTR_W       = 15,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             sda_oe,
  input  logic             wr_inhibit,
  output logic [PTR_W-1:0] ram_addr,
  output logic             ram_we,
  output logic [7:0]       ram_wdata,
  input  logic [7:0]       ram_rdata
);
  logic       sda_s;
  logic       scl_rise;
  logic       scl_fall;
  logic       start_ev;
  logic       stop_ev;
  logic       ptr_load;
  logic       ptr_inc;
  logic [7:0] ptr_hi;
  logic [7:0] ptr_lo;

  i2cmem_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  i2cmem_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_ev   (start_ev),
    .stop_ev    (stop_ev),
    .sda_s      (sda_s),
    .wr_inhibit (wr_inhibit),
    .ram_rdata  (ram_rdata),
    .sda_oe     (sda_oe),
    .ram_we     (ram_we),
    .ram_wdata  (ram_wdata),
    .ptr_load   (ptr_load),
    .ptr_hi     (ptr_hi),
    .ptr_lo     (ptr_lo),
    .ptr_inc    (ptr_inc)
  );

  i2cmem_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (ptr_load),
    .hi    (ptr_hi),
    .lo    (ptr_lo),
    .inc   (ptr_inc),
    .ptr   (ram_addr)
  );
endmodule

// File: rtl/i2cmem_chk.sv
module i2cmem_chk #(
  parameter int PTR_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sda_oe,
  input logic             wr_inhibit,
  input logic [PTR_W-1:0] ram_addr,
  input logic             ram_we,
  input logic             scl_fall,
  input logic             start_ev,
  input logic             stop_ev,
  input logic             ptr_inc,
  input logic             ptr_load
);
  // R9
  inhibit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_inhibit |=> !sda_oe);

  // R3
  oe_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));

  // R5
  we_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (scl_fall && !ptr_load));

  // R5
  we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> !ram_we);

  // R7
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_inc && !ptr_load) |=> ram_addr == PTR_W'($past(ram_addr) + 1'b1));

  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe);

  // R10
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !sda_oe);
endmodule

bind i2c_ram_slave i2cmem_chk #(.PTR_W(PTR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sda_oe     (sda_oe),
  .wr_inhibit (wr_inhibit),
  .ram_addr   (ram_addr),
  .ram_we     (ram_we),
  .scl_fall   (scl_fall),
  .start_ev   (start_ev),
  .stop_ev    (stop_ev),
  .ptr_inc    (ptr_inc),
  .ptr_load   (ptr_load)
);

// File: tb/tb_i2c_ram_slave.sv
module tb_i2c_ram_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 6;
  localparam int PTR_W = 15;
  localparam logic [7:0] WR_B = 8'hA4; // address 7'h52, write
  localparam logic [7:0] RD_B = 8'hA5; // address 7'h52, read

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic wr_inhibit = 1'b0;
  logic sda_oe;
  logic [PTR_W-1:0] ram_addr;
  logic ram_we;
  logic [7:0] ram_wdata;
  logic [7:0] ram_rdata = 8'h00;
  logic sda_line;
  assign sda_line = sda_m & ~sda_oe;

  int n_cmp = 0;
  int n_bad = 0;
  int we_cnt = 0;
  int oe_cnt = 0;
  bit done = 1'b0;
  logic [7:0] mem [int unsigned];

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_ram_slave #(.DEV_ADDR(7'h52), .PTR_W(PTR_W)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_in     (scl_m),
    .sda_in     (sda_line),
    .sda_oe     (sda_oe),
    .wr_inhibit (wr_inhibit),
    .ram_addr   (ram_addr),
    .ram_we     (ram_we),
    .ram_wdata  (ram_wdata),
    .ram_rdata  (ram_rdata)
  );

  always @(posedge clk) begin
    if (ram_we) begin
      mem[int'(ram_addr)] = ram_wdata;
      we_cnt++;
    end
    if (sda_oe) oe_cnt++;
    ram_rdata <= mem.exists(int'(ram_addr)) ? mem[int'(ram_addr)] : 8'h00;
  end

  function automatic logic [7:0] peek(input int unsigned a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    sda_m = b;    tick(Q);
    scl_m = 1'b1; tick(Q);
    s = sda_line; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic give_ack);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(~give_ack, s);
  endtask

  task automatic t_reset();
    chk("R11 sda released", int'(sda_oe), 0);
    chk("R11 pointer zero", int'(ram_addr), 0);
    chk("R11 no write", int'(ram_we), 0);
  endtask

  task automatic t_write_seq();
    logic a;
    int w0;
    w0 = we_cnt;
    bus_start();
    send_byte(WR_B, a); chk("R1 device ack", int'(a), 1);
    send_byte(8'h92, a); chk("R3 high byte ack", int'(a), 1);
    send_byte(8'h34, a); chk("R3 low byte ack", int'(a), 1);
    send_byte(8'h11, a); chk("R5 data ack", int'(a), 1);
    send_byte(8'h22, a);
    send_byte(8'h33, a);
    bus_stop();
    chk("R5 write count", we_cnt - w0, 3);
    chk("R4 R5 pointer after write", int'(ram_addr), 'h1237);
    chk("R5 byte 0x1234", int'(peek('h1234)), 'h11);
    chk("R5 byte 0x1235", int'(peek('h1235)), 'h22);
    chk("R5 byte 0x1236", int'(peek('h1236)), 'h33);
  endtask

  task automatic t_random_read();
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte(WR_B, a);
    send_byte(8'h12, a);
    send_byte(8'h34, a);
    bus_start();
    send_byte(RD_B, a); chk("R1 read device ack", int'(a), 1);
    recv_byte(d, 1'b1); chk("R6 read 0x1234", int'(d), 'h11);
    recv_byte(d, 1'b1); chk("R6 read 0x1235", int'(d), 'h22);
    recv_byte(d, 1'b0); chk("R6 read 0x1236", int'(d), 'h33);
    bus_stop();
    chk("R6 pointer held on nack", int'(ram_addr), 'h1236);
  endtask

  task automatic t_current_read();
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte(RD_B, a); chk("R8 current read ack", int'(a), 1);
    recv_byte(d, 1'b0); chk("R8 current read data", int'(d), 'h33);
    bus_stop();
  endtask

  task automatic t_wrap();
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte(WR_B, a);
    send_byte(8'hFF, a);
    send_byte(8'hFF, a);
    send_byte(8'hC5, a);
    send_byte(8'h5A, a);
    bus_stop();
    chk("R7 top byte", int'(peek('h7FFF)), 'hC5);
    chk("R7 wrapped byte", int'(peek(0)), 'h5A);
    chk("R7 pointer after write wrap", int'(ram_addr), 1);
    bus_start();
    send_byte(WR_B, a);
    send_byte(8'h7F, a);
    send_byte(8'hFF, a);
    bus_start();
    send_byte(RD_B, a);
    recv_byte(d, 1'b1); chk("R7 read top", int'(d), 'hC5);
    recv_byte(d, 1'b0); chk("R7 read wrapped", int'(d), 'h5A);
    bus_stop();
    chk("R7 pointer after read wrap", int'(ram_addr), 0);
  endtask

  task automatic t_wrong_addr();
    logic a;
    int w0, o0;
    w0 = we_cnt; o0 = oe_cnt;
    bus_start();
    send_byte(8'hA0, a); chk("R2 no ack on mismatch", int'(a), 0);
    send_byte(8'h00, a);
    send_byte(8'h00, a);
    send_byte(8'h77, a);
    bus_stop();
    chk("R2 sda silent", oe_cnt - o0, 0);
    chk("R2 no write", we_cnt - w0, 0);
  endtask

  task automatic t_inhibit();
    logic a;
    int w0, o0;
    w0 = we_cnt; o0 = oe_cnt;
    wr_inhibit = 1'b1;
    tick(2);
    bus_start();
    send_byte(WR_B, a); chk("R9 no ack inhibited", int'(a), 0);
    send_byte(8'h00, a);
    send_byte(8'h10, a);
    send_byte(8'h99, a);
    bus_stop();
    chk("R9 no write", we_cnt - w0, 0);
    chk("R9 sda silent", oe_cnt - o0, 0);
    chk("R9 pointer unchanged", int'(ram_addr), 0);
    wr_inhibit = 1'b0;
    tick(2);
  endtask

  task automatic t_rstart_abort();
    logic a, s;
    logic [7:0] d;
    bus_start();
    send_byte(WR_B, a);
    for (int i = 0; i < 4; i++) clk_bit(1'b1, s);
    bus_start();
    send_byte(RD_B, a); chk("R10 ack after repeated start", int'(a), 1);
    recv_byte(d, 1'b0); chk("R10 data after abort", int'(d), 'h5A);
    bus_stop();
    chk("R10 pointer kept after abort", int'(ram_addr), 0);
  endtask

  task automatic t_after_stop();
    logic a;
    int o0;
    bus_start();
    send_byte(WR_B, a);
    send_byte(8'h00, a);
    bus_stop();
    o0 = oe_cnt;
    scl_m = 1'b0; tick(Q);
    send_byte(WR_B, a); chk("R10 no ack after stop", int'(a), 0);
    chk("R10 sda silent after stop", oe_cnt - o0, 0);
    bus_stop();
    chk("R10 pointer after stop", int'(ram_addr), 0);
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_write_seq();
    t_random_read();
    t_current_read();
    t_wrap();
    t_wrong_addr();
    t_inhibit();
    t_rstart_abort();
    t_after_stop();
    tick(10);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule